// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block takes the first six bytes of a received frame, the destination address, and decides whether the frame is kept. It compares the address with the station's own programmed address and recognises the all-ones broadcast address. For group (multicast) addresses it consults a 64-bit hash table. Two mode inputs widen acceptance: one accepts every group address, and one accepts every frame.

Bytes arrive one per valid cycle, in the order they appear on the cable. A start marker on the first byte begins a new address. The 6-bit hash is computed elsewhere from the frame check sequence of the destination address and is presented together with the sixth byte. The block answers with a single registered pulse that carries an accept flag and a code for the kind of match. A receive path uses this pulse to commit the frame or to drop it.

Top module: `rx_addr_filter`

## Requirements
- R1: A byte taken with `rx_valid` and `rx_sof` both high is address byte 0. The next five bytes taken with `rx_valid` high are bytes 1 to 5. Address byte k is compared with `station_addr[8k+7:8k]`. Bit 0 of byte 0 is the first bit on the cable.
- R2: If all six bytes equal the station address and the address is not broadcast, the frame is accepted with `dec_kind` 0 (individual).
- R3: If all six bytes are 0xFF (broadcast), the frame is accepted with `dec_kind` 1, regardless of the mode inputs and the table.
- R4: A group address has bit 0 of byte 0 set and is not broadcast. When it does not match the station address, it is accepted with `dec_kind` 2 in either of two cases: `allmulti_en` is high, or the table bit selected by the hash is set. `crc_hash[5:3]` picks table byte `mcast_table[8j+7:8j]`, and `crc_hash[2:0]` picks the bit within that byte. For example, hash 6'b100111 selects table bit 39.
- R5: A group address whose selected table bit is clear, with `allmulti_en` low and `promisc_en` low, is rejected.
- R6: With `promisc_en` high, every frame is accepted. A frame that matches none of R2 to R4 is reported with `dec_kind` 3. A frame that matches one of them keeps that kind.
- R7: An individual address (bit 0 of byte 0 clear) that differs from the station address in any bit is rejected when `promisc_en` is low.
- R8: `dec_valid` is high for exactly the one cycle after the clock edge at which the sixth address byte is taken. The hash, the mode inputs, the table and the station address are used as they stand at that edge. `dec_accept` and `dec_kind` are 0 whenever `dec_valid` is low.
- R9: Bytes taken before any start marker, and bytes after the sixth, are ignored. A new start marker restarts the address at byte 0, including in the middle of an address. Idle cycles between address bytes are allowed.
- R10: A rejected decision reports `dec_kind` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present |
| rx_sof | input | 1 | Marks the first destination byte of a frame |
| rx_byte | input | BYTE_W (8) | Received byte |
| crc_hash | input | HASH_W (6) | Hash of the destination address, valid with the sixth byte |
| promisc_en | input | 1 | Accept every frame |
| allmulti_en | input | 1 | Accept every group address |
| station_addr | input | ADDR_BYTES*BYTE_W (48) | Own address; byte k in bits [8k+7:8k] |
| mcast_table | input | 2**HASH_W (64) | Group hash table |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 2 | 0 individual, 1 broadcast, 2 group, 3 promiscuous |

## Verification
The bench builds two instances with the default widths: a six-byte address, 8-bit bytes and a 6-bit hash. The two differ only in `MATCH_STYLE`, so both the running-compare variant and the capture-then-compare variant meet the same reference every cycle. With a 6-bit hash, random table contents and random hashes reach all 64 table bits. The default byte count brings gaps between bytes, restarts in mid-address and trailing bytes within reach of the byte sequencer.

// File: rtl/raf_pkg.sv
package raf_pkg;
   typedef enum logic [1:0] {
      MK_INDIV   = 2'd0,
      MK_BCAST   = 2'd1,
      MK_MCAST   = 2'd2,
      MK_PROMISC = 2'd3
   } match_kind_e;
endpackage

// File: rtl/raf_byte_seq.sv
// Tracks which destination byte is on the input.
module raf_byte_seq #(
   parameter int ADDR_BYTES = 6,
   parameter int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   output logic             take,
   output logic             first,
   output logic             last,
   output logic [CNT_W-1:0] idx
);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      first = in_valid && in_sof;
      take  = first || (in_valid && (cnt_q != '0) && (cnt_q < FULL));
      idx   = first ? '0 : cnt_q;
      last  = take && (idx == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (take)
         cnt_q <= idx + 1'b1;
   end
endmodule

// File: rtl/raf_addr_cmp.sv
// Address comparison: running flags (style 0) or capture then compare (style 1).
module raf_addr_cmp #(
   parameter int ADDR_BYTES  = 6,
   parameter int BYTE_W      = 8,
   parameter int CNT_W       = $clog2(ADDR_BYTES + 1),
   parameter int MATCH_STYLE = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         take,
   input  logic                         first,
   input  logic [CNT_W-1:0]             idx,
   input  logic [BYTE_W-1:0]            in_byte,
   input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
   output logic                         ind_eq,
   output logic                         bc_eq,
   output logic                         mc_bit
);
   generate
      if (MATCH_STYLE == 0) begin : g_running
         logic [BYTE_W-1:0] sta_bytes [ADDR_BYTES];
         logic [BYTE_W-1:0] sta_byte;
         logic              byte_eq, byte_ff, ind_now, bc_now;
         logic              ind_q, bc_q, mc_q;

         for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_split
            assign sta_bytes[k] = station_addr[k*BYTE_W +: BYTE_W];
         end

         always_comb begin
            sta_byte = '0;
            for (int k = 0; k < ADDR_BYTES; k++)
               if (idx == CNT_W'(k)) sta_byte = sta_bytes[k];
            byte_eq = (in_byte == sta_byte);
            byte_ff = &in_byte;
            ind_now = (first || ind_q) && byte_eq;
            bc_now  = (first || bc_q) && byte_ff;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ind_q <= 1'b0;
               bc_q  <= 1'b0;
               mc_q  <= 1'b0;
            end else if (take) begin
               ind_q <= ind_now;
               bc_q  <= bc_now;
               if (first) mc_q <= in_byte[0];
            end
         end

         assign ind_eq = ind_now;
         assign bc_eq  = bc_now;
         assign mc_bit = first ? in_byte[0] : mc_q;
      end else begin : g_capture
         localparam int ADDR_W = ADDR_BYTES * BYTE_W;
         logic [BYTE_W-1:0] cap_q [ADDR_BYTES-1];
         logic [ADDR_W-1:0] full;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cap_q[0] <= '0;
            else if (first)
               cap_q[0] <= in_byte;
         end

         for (genvar k = 1; k < ADDR_BYTES - 1; k++) begin : g_slot
            always_ff @(posedge clk) begin
               if (!rst_n)
                  cap_q[k] <= '0;
               else if (take && (idx == CNT_W'(k)))
                  cap_q[k] <= in_byte;
            end
         end

         for (genvar k = 0; k < ADDR_BYTES - 1; k++) begin : g_join
            assign full[k*BYTE_W +: BYTE_W] = cap_q[k];
         end
         assign full[ADDR_W-1 -: BYTE_W] = in_byte;

         assign ind_eq = (full == station_addr);
         assign bc_eq  = &full;
         assign mc_bit = full[0];
      end
   endgenerate
endmodule

// File: rtl/raf_hash_lookup.sv
// Upper hash bits pick a table byte, lower bits pick the bit in it.
module raf_hash_lookup #(
   parameter int HASH_W = 6,
   parameter int BYTE_W = 8
) (
   input  logic [(1<<HASH_W)-1:0] table_bits,
   input  logic [HASH_W-1:0]      hash,
   output logic                   hit
);
   localparam int SEL_W = $clog2(BYTE_W);
   localparam int ROW_W = HASH_W - SEL_W;
   localparam int ROWS  = 1 << ROW_W;

   logic [BYTE_W-1:0] rows [ROWS];
   logic [BYTE_W-1:0] row_sel;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign rows[r] = table_bits[r*BYTE_W +: BYTE_W];
   end

   always_comb begin
      row_sel = rows[hash[HASH_W-1:SEL_W]];
      hit     = row_sel[hash[SEL_W-1:0]];
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
   parameter int ADDR_BYTES  = 6,
   parameter int BYTE_W      = 8,
   parameter int HASH_W      = 6,
   parameter int MATCH_STYLE = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rx_valid,
   input  logic                         rx_sof,
   input  logic [BYTE_W-1:0]            rx_byte,
   input  logic [HASH_W-1:0]            crc_hash,
   input  logic                         promisc_en,
   input  logic                         allmulti_en,
   input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
   input  logic [(1<<HASH_W)-1:0]       mcast_table,
   output logic                         dec_valid,
   output logic                         dec_accept,
   output logic [1:0]                   dec_kind
);
   import raf_pkg::*;

   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam int SEL_W = $clog2(BYTE_W);

   generate
      if (ADDR_BYTES < 2) begin : g_bad_bytes
         $error("ADDR_BYTES must be at least 2");
      end
      if ((1 << SEL_W) != BYTE_W) begin : g_bad_width
         $error("BYTE_W must be a power of two");
      end
      if (HASH_W <= SEL_W) begin : g_bad_hash
         $error("HASH_W must exceed log2(BYTE_W)");
      end
      if ((MATCH_STYLE != 0) && (MATCH_STYLE != 1)) begin : g_bad_style
         $error("MATCH_STYLE must be 0 or 1");
      end
   endgenerate

   logic             take, first, last;
   logic [CNT_W-1:0] idx;
   logic             ind_eq, bc_eq, mc_bit, hash_hit;

   raf_byte_seq #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_sof(rx_sof),
      .take(take), .first(first), .last(last), .idx(idx)
   );

   raf_addr_cmp #(
      .ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .MATCH_STYLE(MATCH_STYLE)
   ) u_cmp (
      .clk(clk), .rst_n(rst_n), .take(take), .first(first), .idx(idx),
      .in_byte(rx_byte), .station_addr(station_addr),
      .ind_eq(ind_eq), .bc_eq(bc_eq), .mc_bit(mc_bit)
   );

   raf_hash_lookup #(.HASH_W(HASH_W), .BYTE_W(BYTE_W)) u_hash (
      .table_bits(mcast_table), .hash(crc_hash), .hit(hash_hit)
   );

   match_kind_e kind_n;
   logic        acc_n;

   // Priority: broadcast, own address, group, promiscuous.
   always_comb begin
      kind_n = MK_INDIV;
      acc_n  = 1'b0;
      if (bc_eq) begin
         kind_n = MK_BCAST;
         acc_n  = 1'b1;
      end else if (ind_eq) begin
         kind_n = MK_INDIV;
         acc_n  = 1'b1;
      end else if (mc_bit && (allmulti_en || hash_hit)) begin
         kind_n = MK_MCAST;
         acc_n  = 1'b1;
      end else if (promisc_en) begin
         kind_n = MK_PROMISC;
         acc_n  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_kind   <= MK_INDIV;
      end else begin
         dec_valid  <= last;
         dec_accept <= last && acc_n;
         dec_kind   <= (last && acc_n) ? kind_n : MK_INDIV;
      end
   end
endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
   parameter int ADDR_BYTES = 6,
   parameter int BYTE_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rx_sof,
   input logic [BYTE_W-1:0] rx_byte,
   input logic              promisc_en,
   input logic              allmulti_en,
   input logic              dec_valid,
   input logic              dec_accept,
   input logic [1:0]        dec_kind
);
   import raf_pkg::*;

   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] ck_cnt;
   logic             ck_ff_q, ck_mc_q;
   logic             ck_first, ck_take, ck_last, ck_ff_now, ck_mc_now;
   logic [CNT_W-1:0] ck_pos;

   always_comb begin
      ck_first  = rx_valid && rx_sof;
      ck_take   = ck_first || (rx_valid && (ck_cnt != '0) && (ck_cnt < FULL));
      ck_pos    = ck_first ? '0 : ck_cnt;
      ck_last   = ck_take && (ck_pos == LAST);
      ck_ff_now = (ck_first || ck_ff_q) && (&rx_byte);
      ck_mc_now = ck_first ? rx_byte[0] : ck_mc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_cnt  <= '0;
         ck_ff_q <= 1'b0;
         ck_mc_q <= 1'b0;
      end else if (ck_take) begin
         ck_cnt  <= ck_pos + 1'b1;
         ck_ff_q <= ck_ff_now;
         ck_mc_q <= ck_mc_now;
      end
   end

   a_r8_decision_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ck_last |=> dec_valid);
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(ck_last));
   a_r8_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!dec_accept && dec_kind == MK_INDIV));
   a_r10_reject_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_accept) |-> dec_kind == MK_INDIV);
   a_r6_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(promisc_en)) |-> dec_accept);
   a_r4_allmulti_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(allmulti_en && ck_mc_now)) |-> dec_accept);
   a_r3_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(ck_ff_now)) |-> (dec_accept && dec_kind == MK_BCAST));
endmodule

bind rx_addr_filter raf_checker #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_raf_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
   .promisc_en(promisc_en), .allmulti_en(allmulti_en),
   .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_kind(dec_kind)
);

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [5:0]  crc_hash = 6'd0;
   logic        promisc_en = 1'b0, allmulti_en = 1'b0;
   logic [47:0] station_addr = 48'hA5_34_12_9C_E0_02;
   logic [63:0] mcast_table = 64'd0;

   logic       v0, a0, v1, a1;
   logic [1:0] k0, k1;

   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rx_addr_filter #(.MATCH_STYLE(0)) i_rx_addr_filter (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
      .crc_hash(crc_hash), .promisc_en(promisc_en), .allmulti_en(allmulti_en),
      .station_addr(station_addr), .mcast_table(mcast_table),
      .dec_valid(v0), .dec_accept(a0), .dec_kind(k0));

   rx_addr_filter #(.MATCH_STYLE(1)) i_rx_addr_filter_cap (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
      .crc_hash(crc_hash), .promisc_en(promisc_en), .allmulti_en(allmulti_en),
      .station_addr(station_addr), .mcast_table(mcast_table),
      .dec_valid(v1), .dec_accept(a1), .dec_kind(k1));

   // Behavioural reference model
   byte unsigned q[$];
   logic       exp_v = 0, exp_a = 0;
   logic [1:0] exp_k = 0;
   string      exp_tag = "R8", cur_tag = "R8";

   always @(posedge clk) begin
      bit took, bc, ind, mc, hit;
      logic [7:0] tb_byte;
      if (!rst_n) begin
         q.delete();
         exp_v = 0; exp_a = 0; exp_k = 0;
      end else begin
         took = 0;
         exp_v = 0; exp_a = 0; exp_k = 0; exp_tag = "R8";
         if (rx_valid) begin
            if (rx_sof) begin
               q.delete(); q.push_back(rx_byte); took = 1;
            end else if (q.size() > 0 && q.size() < 6) begin
               q.push_back(rx_byte); took = 1;
            end
         end
         if (took && q.size() == 6) begin
            bc = 1; ind = 1;
            for (int k = 0; k < 6; k++) begin
               if (q[k] != 8'hFF) bc = 0;
               if (q[k] != station_addr[8*k +: 8]) ind = 0;
            end
            mc = q[0][0];
            tb_byte = mcast_table[(int'(crc_hash) / 8) * 8 +: 8];
            hit = tb_byte[int'(crc_hash) % 8];
            exp_v = 1;
            if (bc)                       begin exp_a = 1; exp_k = 2'd1; end
            else if (ind)                 begin exp_a = 1; exp_k = 2'd0; end
            else if (mc && (allmulti_en || hit)) begin exp_a = 1; exp_k = 2'd2; end
            else if (promisc_en)          begin exp_a = 1; exp_k = 2'd3; end
            exp_tag = exp_a ? cur_tag : {cur_tag, "/R10"};
         end
      end
   end

   task automatic check_one(input string inst, input logic v, input logic a, input logic [1:0] k);
      string tag;
      checks++;
      tag = exp_v ? exp_tag : "R8";
      if (v !== exp_v || a !== exp_a || k !== exp_k) begin
         fails++;
         $display("FAIL %s %s: valid/accept/kind = %b/%b/%0d, expected %b/%b/%0d",
                  tag, inst, v, a, k, exp_v, exp_a, exp_k);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check_one("style0", v0, a0, k0);
         check_one("style1", v1, a1, k1);
      end
   end

   task automatic drive(input logic v, input logic s, input logic [7:0] d);
      rx_valid = v; rx_sof = s; rx_byte = d;
      @(negedge clk);
   endtask

   task automatic send_frame(input logic [47:0] a, input int gap, input int extra);
      for (int k = 0; k < 6; k++) begin
         drive(1'b1, k == 0, a[8*k +: 8]);
         if (k < 5) repeat (gap) drive(1'b0, 1'b0, 8'h00);
      end
      for (int e = 0; e < extra; e++) drive(1'b1, 1'b0, 8'($urandom));
      drive(1'b0, 1'b0, 8'h00);
      drive(1'b0, 1'b0, 8'h00);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [47:0] a;
      repeat (4) @(negedge clk);
      // R8: reset state of the outputs
      checks++;
      if (v0 !== 0 || a0 !== 0 || k0 !== 0 || v1 !== 0 || a1 !== 0 || k1 !== 0) begin
         fails++;
         $display("FAIL R8 reset: outputs %b%b%0d/%b%b%0d, expected 000", v0, a0, k0, v1, a1, k1);
      end
      rst_n = 1'b1;
      @(negedge clk);

      cur_tag = "R2"; send_frame(station_addr, 0, 0);
      cur_tag = "R1"; send_frame({station_addr[7:0], station_addr[15:8], station_addr[23:16],
                                  station_addr[31:24], station_addr[39:32], station_addr[47:40]}, 0, 0);
      cur_tag = "R1"; send_frame(station_addr ^ 48'h1, 0, 0);
      cur_tag = "R3"; send_frame(48'hFFFF_FFFF_FFFF, 0, 0);

      // R4: hash 100111 selects byte 4 bit 7 (table bit 39)
      mcast_table = 64'd1 << 39;
      crc_hash = 6'b100111;
      cur_tag = "R4"; send_frame(48'h66_55_44_33_22_01, 0, 0);
      crc_hash = 6'b100110;
      cur_tag = "R5"; send_frame(48'h66_55_44_33_22_01, 0, 0);
      allmulti_en = 1;
      cur_tag = "R4"; send_frame(48'h66_55_44_33_22_01, 0, 0);
      allmulti_en = 0;

      cur_tag = "R7"; send_frame(station_addr ^ 48'h80_0000_0000, 0, 0);
      promisc_en = 1;
      cur_tag = "R6"; send_frame(station_addr ^ 48'h80_0000_0000, 0, 0);
      cur_tag = "R6"; send_frame(station_addr, 0, 0);
      cur_tag = "R6"; send_frame(48'hFFFF_FFFF_FFFF, 0, 0);
      promisc_en = 0;

      cur_tag = "R8"; send_frame(station_addr, 3, 0);
      // R9: trailing bytes, stray bytes without a start, restart mid-address
      cur_tag = "R9"; send_frame(station_addr, 1, 5);
      repeat (3) drive(1'b1, 1'b0, 8'hFF);
      drive(1'b0, 1'b0, 8'h00);
      drive(1'b1, 1'b1, 8'hFF);
      drive(1'b1, 1'b0, 8'hFF);
      drive(1'b1, 1'b0, 8'hFF);
      cur_tag = "R9"; send_frame(station_addr, 0, 0);

      for (int n = 0; n < 300; n++) begin
         case ($urandom % 4)
            0: a = station_addr;
            1: a = 48'hFFFF_FFFF_FFFF;
            2: a = {$urandom, 16'($urandom)} | 48'h1;
            default: a = {$urandom, 16'($urandom)};
         endcase
         mcast_table = {$urandom, $urandom};
         crc_hash    = 6'($urandom);
         promisc_en  = ($urandom % 4) == 0;
         allmulti_en = ($urandom % 4) == 0;
         cur_tag = "R1";
         send_frame(a, $urandom % 3, $urandom % 2);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule